// File: doc/BRIEF.md
# Programmable Butterfly Bit Network

This block transforms one data word through a chain of log2(XLEN) butterfly stages. Stage k pairs every bit position j with position j XOR 2^k. A stage whose bit in the control amount is clear passes the word through unchanged. A stage whose bit is set replaces every bit with a two-input Boolean function of itself and of its partner. In the fixed swap mode each bit takes its partner's value. This is the generalized reverse, which covers adjacent-bit swaps, nibble and byte reversal, half-word swaps and full bit reversal. In the fixed OR mode each bit becomes the OR of itself and its partner.

In table mode the function comes from an 8-bit immediate that holds two 4-entry truth tables. The low nibble serves the bits whose stage-k index bit is 0. The high nibble serves the bits whose stage-k index bit is 1. A zero-input flag replaces the data word with all zeros. With that flag set, table mode generates repeating constant patterns from the immediate and the control amount alone.

The network is combinational and feeds one output register, so a result appears on the clock edge after its operands.

Top module: `bit_lut_butterfly`

## Requirements
- R1: While rst_n is low, result_o is all zeros.
- R2: Only the low log2(XLEN) bits of amount_i take part. Higher bits have no effect on result_o.
- R3: Stage k, with chunk 2^k, is active exactly when amount_i bit k is set. It pairs bit j with bit j XOR 2^k. Stages run in increasing chunk order, so an amount of XLEN-1 in swap mode reverses the word.
- R4: The order of stages is observable in table mode. With XLEN=64, zero_i=1, amount 3 and immediate 0x30, the result is 0x4444444444444444.
- R5: mode_i = 2'b00 selects swap mode. Each bit of an active stage takes its partner's value. Amount 1 exchanges adjacent bits, amount 32 exchanges the two 32-bit halves, and the count of set bits is preserved.
- R6: mode_i = 2'b01 selects OR mode. Each bit of an active stage becomes the OR of itself and its partner, so every set input bit stays set.
- R7: mode_i[1] = 1 selects table mode. The output bit is imm bit ((partner<<1)|self) within a nibble. The nibble is imm_i[3:0] when bit k of the position j is 0, and imm_i[7:4] when it is 1.
- R8: In table mode, immediate 0xCC gives the same result as swap mode and immediate 0xEE gives the same result as OR mode, for any data and amount.
- R9: With zero_i=1 the network input is all zeros and data_i has no effect. In swap and OR modes the result is zero. In table mode the result depends only on the immediate and the amount.
- R10: result_o shows the function of the inputs sampled at the previous rising clock edge, and it holds until the next edge.
- R11: In swap and OR modes imm_i has no effect, and mode_i = 2'b11 behaves like 2'b10.
- R12: With the masked amount zero, result_o equals data_i, or zero when zero_i is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 swap, 01 OR, 1x table |
| zero_i | input | 1 | Force network input to zero |
| data_i | input | XLEN | Word to transform |
| amount_i | input | XLEN | Stage enables, low log2(XLEN) bits used |
| imm_i | input | 8 | Two 4-entry tables, low nibble for lower pair members |
| result_o | output | XLEN | Registered transformed word |

## Verification
The bench builds the block with the default XLEN of 64. That width gives six stages, so the 32-bit half exchange and full 64-bit reversal can be exercised. It also puts amount bit 6 and every bit above it outside the used field, which lets the bench check that those bits are ignored. At this width the 64-bit constant patterns from the zero-input option can be written out in full. Together these settings reach every stage distance and both table halves at each of them.

// File: rtl/bit_lut_butterfly.sv
module bit_lut_butterfly #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_i,
  input  logic            zero_i,
  input  logic [XLEN-1:0] data_i,
  input  logic [XLEN-1:0] amount_i,
  input  logic [7:0]      imm_i,
  output logic [XLEN-1:0] result_o
);
  localparam int STAGES = $clog2(XLEN);

  logic [XLEN-1:0] net [STAGES+1];
  logic [STAGES-1:0] stage_en;

  assign stage_en = amount_i[STAGES-1:0];
  assign net[0]   = zero_i ? '0 : data_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int CHUNK = 1 << k;
    for (genvar j = 0; j < XLEN; j++) begin : g_bit
      localparam int PARTNER = j ^ CHUNK;
      localparam bit UPPER = ((j >> k) & 1) != 0;
      logic self_b, part_b, lut_b, f_b;
      logic [3:0] table_w;
      assign self_b  = net[k][j];
      assign part_b  = net[k][PARTNER];
      assign table_w = UPPER ? imm_i[7:4] : imm_i[3:0];
      assign lut_b   = table_w[{part_b, self_b}];
      assign f_b     = mode_i[1] ? lut_b :
                       mode_i[0] ? (self_b | part_b) : part_b;
      assign net[k+1][j] = stage_en[k] ? f_b : self_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_o <= '0;
    else        result_o <= net[STAGES];
  end

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  assert_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && ($past(amount_i[STAGES-1:0]) == '0) |->
      result_o == ($past(zero_i) ? '0 : $past(data_i)));

  assert_swap_popcount_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && ($past(mode_i) == 2'b00) && !$past(zero_i) |->
      $countones(result_o) == $countones($past(data_i)));

  assert_or_keeps_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && ($past(mode_i) == 2'b01) && !$past(zero_i) |->
      (result_o & $past(data_i)) == $past(data_i));

  assert_zero_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && !$past(mode_i[1]) && $past(zero_i) |-> result_o == '0);

  assert_lut_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(mode_i[1]) && ($past(imm_i) == 8'h00) &&
    ($past(amount_i[STAGES-1:0]) != '0) |-> result_o == '0);

  assert_lut_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(mode_i[1]) && ($past(imm_i) == 8'hFF) &&
    ($past(amount_i[STAGES-1:0]) != '0) |-> result_o == '1);
endmodule

// File: tb/sim_bit_lut_butterfly.sv
module sim_bit_lut_butterfly;
  localparam int XLEN = 64;
  localparam int NV = 13;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode_i = 2'b00;
  logic            zero_i = 1'b0;
  logic [XLEN-1:0] data_i = '0;
  logic [XLEN-1:0] amount_i = '0;
  logic [7:0]      imm_i = 8'h00;
  logic [XLEN-1:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bit_lut_butterfly #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .zero_i(zero_i),
    .data_i(data_i), .amount_i(amount_i), .imm_i(imm_i), .result_o(result_o)
  );

  localparam logic [1:0] T_MODE [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1,
    2'd2, 2'd3, 2'd2, 2'd0, 2'd2, 2'd2, 2'd2};
  localparam logic T_ZERO [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [63:0] T_AMT [NV] = '{64'd1, 64'd32, 64'd63, 64'd56, 64'd7, 64'd63,
    64'd1, 64'd5, 64'd1, 64'hFFFF_FFFF_FFFF_FFC0, 64'd1, 64'd3, 64'd63};
  localparam logic [7:0] T_IMM [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h5A,
    8'h00, 8'hAA, 8'h0C, 8'h00, 8'hF0, 8'h30, 8'hCC};
  localparam logic [63:0] T_DATA [NV] = '{64'h1, 64'h0123456789ABCDEF, 64'h1,
    64'h0123456789ABCDEF, 64'h100, 64'h1, 64'hDEADBEEFCAFEF00D, 64'h0123456789ABCDEF,
    64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF, 64'h1234, 64'hFFFFFFFFFFFFFFFF,
    64'h0123456789ABCDEF};
  localparam logic [63:0] T_EXP [NV] = '{64'h2, 64'h89ABCDEF01234567, 64'h8000000000000000,
    64'hEFCDAB8967452301, 64'hFF00, 64'hFFFFFFFFFFFFFFFF, 64'h0, 64'h0123456789ABCDEF,
    64'h5555555555555555, 64'h0123456789ABCDEF, 64'hAAAAAAAAAAAAAAAA,
    64'h4444444444444444, 64'hF7B3D591E6A2C480};
  localparam string T_REQ [NV] = '{"R5", "R5", "R3", "R3", "R6", "R11", "R7", "R11",
    "R7", "R2", "R9", "R4", "R8"};

  function automatic logic [63:0] ref_net(input logic [63:0] d, input logic [63:0] amt,
                                          input logic [7:0] imm, input logic z,
                                          input logic [1:0] m);
    logic [63:0] x, y;
    logic s, q;
    logic [3:0] t;
    int p;
    x = z ? 64'h0 : d;
    for (int k = 0; k < 6; k++) begin
      if (amt[k]) begin
        for (int j = 0; j < 64; j++) begin
          p = j ^ (1 << k);
          s = x[j];
          q = x[p];
          t = (((j >> k) & 1) != 0) ? imm[7:4] : imm[3:0];
          if (m[1])      y[j] = t[{q, s}];
          else if (m[0]) y[j] = s | q;
          else           y[j] = q;
        end
        x = y;
      end
    end
    return x;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic z, input logic [63:0] amt,
                       input logic [7:0] imm, input logic [63:0] d);
    mode_i = m; zero_i = z; amount_i = amt; imm_i = imm; data_i = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, a, r1;
    logic [7:0] im;
    data_i = 64'hFFFF_0000_FFFF_0000;
    repeat (3) @(negedge clk);
    check("R1", result_o, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(T_MODE[i], T_ZERO[i], T_AMT[i], T_IMM[i], T_DATA[i]);
      check(T_REQ[i], result_o, T_EXP[i]);
    end

    // R12: no stage enabled
    apply(2'd2, 1'b0, 64'h0, 8'h00, 64'hA5A5_1234_5678_9ABC);
    check("R12", result_o, 64'hA5A5_1234_5678_9ABC);
    apply(2'd1, 1'b1, 64'h0, 8'hFF, 64'hA5A5_1234_5678_9ABC);
    check("R12", result_o, 64'h0);

    // R10: output holds until the next edge
    apply(2'd0, 1'b0, 64'd32, 8'h00, 64'h0000_0000_FFFF_FFFF);
    mode_i = 2'd1; amount_i = 64'd0; data_i = 64'h1;
    #1;
    check("R10", result_o, 64'hFFFF_FFFF_0000_0000);
    @(posedge clk);
    @(negedge clk);
    check("R10", result_o, 64'h1);

    // R9: data ignored under zero flag in table mode
    apply(2'd2, 1'b1, 64'd21, 8'h6B, 64'h0);
    r1 = result_o;
    apply(2'd2, 1'b1, 64'd21, 8'h6B, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R9", result_o, r1);
    check("R9", result_o, ref_net(64'h0, 64'd21, 8'h6B, 1'b1, 2'd2));

    for (int i = 0; i < 400; i++) begin
      d  = {$urandom, $urandom};
      a  = {$urandom, $urandom};
      im = 8'($urandom);
      apply(2'(i % 4), (i % 9) == 0, a, im, d);
      check(i % 4 == 0 ? "R5" : i % 4 == 1 ? "R6" : "R7", result_o,
            ref_net(d, a, im, (i % 9) == 0, 2'(i % 4)));
    end

    for (int i = 0; i < 60; i++) begin
      d = {$urandom, $urandom};
      a = {58'h0, 6'($urandom)};
      apply(2'd2, 1'b0, a, 8'hCC, d);
      check("R8", result_o, ref_net(d, a, 8'h00, 1'b0, 2'd0));
      apply(2'd3, 1'b0, a, 8'hEE, d);
      check("R8", result_o, ref_net(d, a, 8'h00, 1'b0, 2'd1));
      apply(2'd0, 1'b0, a | 64'hAB00_0000_0000_0040, 8'($urandom), d);
      check("R2", result_o, ref_net(d, a, 8'h00, 1'b0, 2'd0));
    end

    rst_n = 1'b0;
    #1;
    check("R1", result_o, 64'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule